// File: doc/BRIEF.md
# Tone Setting Display Driver

This block shows the two settings of a tone generator on an eight-digit, time-multiplexed seven-segment display. A 3-bit frequency code selects a tone in 500 Hz steps, and the right-hand group of four digits shows that frequency in decimal (0 through 3500). A 3-bit volume code selects a level out of seven, and the left-hand group of four digits shows that level as a rounded whole percentage (0 through 100). No percent sign is drawn.

Only one digit is lit at a time. An internal scan timer holds each digit for `SCAN_DIV` clock cycles. At the default of 100,000 cycles on a 100 MHz clock, each digit stays lit for 1 ms. Leading zeros in each group are blanked, and a value of zero shows a single 0 in the lowest digit. The anode and segment outputs are registered and active low. The decimal points stay dark. The board pin drivers are outside this block.

Top module: `tone_setting_display`

## Requirements
- R1: While `rst` is high at a rising edge, both `anode_n` and `seg_n` become all ones after that edge. The first rising edge after reset is released starts the scan at digit 0, and that digit is shown for `SCAN_DIV` cycles.
- R2: Outside reset, exactly one bit of `anode_n` is low. Bit k low selects digit k. Digits 0–3 form the frequency group and digits 4–7 form the volume group, with the lowest index being the ones place.
- R3: Digits are lit in the order 0, 1, …, 7, and the scan then returns to 0. Each digit stays lit for exactly `SCAN_DIV` consecutive cycles.
- R4: The frequency group shows, in decimal, the frequency code times 500 (0, 500, 1000, …, 3500).
- R5: The volume group shows the volume code times 100 divided by 7, rounded to the nearest integer. Codes 0 to 7 give 0, 14, 29, 43, 57, 71, 86 and 100.
- R6: Within each group, a digit above the ones place is blank (`seg_n` all ones) when the value is smaller than that place's weight. The ones digit is never blank, so a zero value shows a single 0.
- R7: `seg_n[6:0]` drive segments g..a, with bit 0 = a and bit 6 = g. They are active low, so a lit digit's pattern is the inverse of the active-high code: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. `seg_n[7]` is the decimal point and is always 1.
- R8: A change on `freq_code` or `vol_code` appears on the outputs from the first rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_code | input | 3 | Tone frequency selection, 500 Hz per step |
| vol_code | input | 3 | Volume selection, out of 7 |
| anode_n | output | 8 | Active-low digit enables, bit k = digit k |
| seg_n | output | 8 | Active-low segments a..g in bits 0..6, decimal point in bit 7 |

## Verification
The assertions assume that reset is held high from time zero for at least one rising edge, and that after it is released the scan runs freely without another reset. They place no conditions on the two codes, because any 3-bit value is legal. The stimulus raises reset before the first edge and never pulses it again. It changes the codes only at falling edges, so each new code pair is stable when the output registers sample it. It sweeps all 64 code pairs. For each pair it watches a full scan period, starting one cycle after the change.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    localparam int NUM_DIGITS = 8;
    localparam int GROUP_SIZE = 4;
    localparam int VALUE_W    = 14;
    localparam int CODE_W     = 3;

    typedef logic [VALUE_W-1:0] value_t;

    typedef struct packed {
        logic       blank;
        logic [3:0] val;
    } digit_t;

    // Frequency in hertz: 500 Hz per code step.
    function automatic value_t freq_value(input logic [CODE_W-1:0] code);
        return value_t'(code) * value_t'(500);
    endfunction

    // Rounded percentage of code/7.
    function automatic value_t vol_value(input logic [CODE_W-1:0] code);
        int unsigned scaled;
        scaled = (int'(code) * 200 + 7) / 14;
        return value_t'(scaled);
    endfunction

    // Active-high segment pattern, bit 0 = a ... bit 6 = g.
    function automatic logic [6:0] seg_pattern(input digit_t d);
        logic [6:0] pat;
        if (d.blank) begin
            pat = 7'h00;
        end else begin
            case (d.val)
                4'd0:    pat = 7'h3F;
                4'd1:    pat = 7'h06;
                4'd2:    pat = 7'h5B;
                4'd3:    pat = 7'h4F;
                4'd4:    pat = 7'h66;
                4'd5:    pat = 7'h6D;
                4'd6:    pat = 7'h7D;
                4'd7:    pat = 7'h07;
                4'd8:    pat = 7'h7F;
                4'd9:    pat = 7'h6F;
                default: pat = 7'h00;
            endcase
        end
        return pat;
    endfunction

endpackage

// File: rtl/tsd_scan_timer.sv
module tsd_scan_timer #(
    parameter int SCAN_DIV   = 100_000,
    parameter int NUM_DIGITS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    output logic [$clog2(NUM_DIGITS)-1:0] slot
);
    localparam int CNT_W  = (SCAN_DIV > 2) ? $clog2(SCAN_DIV) : 1;
    localparam int SLOT_W = $clog2(NUM_DIGITS);
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(SCAN_DIV - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_DIGITS - 1);

    logic [CNT_W-1:0] dwell;

    always_ff @(posedge clk) begin
        if (rst) begin
            dwell <= '0;
            slot  <= '0;
        end else if (dwell == CNT_LAST) begin
            dwell <= '0;
            slot  <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
        end else begin
            dwell <= dwell + 1'b1;
        end
    end
endmodule

// File: rtl/tsd_digit_source.sv
module tsd_digit_source #(
    parameter int GROUP_SIZE = 4
) (
    input  tsd_pkg::value_t                   value,
    output tsd_pkg::digit_t [GROUP_SIZE-1:0] digits
);
    for (genvar p = 0; p < GROUP_SIZE; p++) begin : g_pos
        localparam int unsigned SCALE = 10 ** p;
        assign digits[p].val = 4'((32'(value) / SCALE) % 10);
        if (p == 0) begin : g_ones
            assign digits[p].blank = 1'b0;
        end else begin : g_upper
            assign digits[p].blank = (32'(value) < SCALE);
        end
    end
endmodule

// File: rtl/tone_setting_display.sv
module tone_setting_display #(
    parameter int SCAN_DIV = 100_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] freq_code,
    input  logic [2:0] vol_code,
    output logic [7:0] anode_n,
    output logic [7:0] seg_n
);
    import tsd_pkg::*;

    localparam int SLOT_W = $clog2(NUM_DIGITS);

    logic [SLOT_W-1:0]             slot;
    digit_t [NUM_DIGITS-1:0]       all_digits;
    value_t                        freq_val;
    value_t                        vol_val;

    assign freq_val = freq_value(freq_code);
    assign vol_val  = vol_value(vol_code);

    tsd_scan_timer #(
        .SCAN_DIV   (SCAN_DIV),
        .NUM_DIGITS (NUM_DIGITS)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    tsd_digit_source #(.GROUP_SIZE(GROUP_SIZE)) u_freq_digits (
        .value  (freq_val),
        .digits (all_digits[GROUP_SIZE-1:0])
    );

    tsd_digit_source #(.GROUP_SIZE(GROUP_SIZE)) u_vol_digits (
        .value  (vol_val),
        .digits (all_digits[NUM_DIGITS-1:GROUP_SIZE])
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            anode_n <= '1;
            seg_n   <= '1;
        end else begin
            anode_n <= ~(NUM_DIGITS'(1) << slot);
            seg_n   <= {1'b1, ~seg_pattern(all_digits[slot])};
        end
    end
endmodule

// File: rtl/tsd_chk.sv
module tsd_chk #(
    parameter int NUM_DIGITS = 8,
    parameter int SCAN_DIV   = 100_000
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_DIGITS-1:0] anode_n,
    input logic [7:0]            seg_n
);
    logic                  armed;
    logic                  armed2;
    logic [NUM_DIGITS-1:0] prev_an;
    int unsigned           run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            armed2  <= 1'b0;
            prev_an <= '1;
            run_len <= 0;
        end else begin
            armed   <= 1'b1;
            armed2  <= armed;
            prev_an <= anode_n;
            run_len <= (anode_n != prev_an) ? 0 : run_len + 1;
        end
    end

    // R1
    reset_blank_chk: assert property (@(posedge clk)
        rst |=> (anode_n == '1 && seg_n == 8'hFF));

    // R2
    one_anode_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> $countones(~anode_n) == 1);

    // R3
    scan_order_chk: assert property (@(posedge clk) disable iff (rst)
        (armed2 && anode_n != prev_an) |->
            anode_n == {prev_an[NUM_DIGITS-2:0], prev_an[NUM_DIGITS-1]});

    // R3
    dwell_limit_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> run_len < SCAN_DIV);

    // R7
    dp_off_chk: assert property (@(posedge clk) disable iff (rst)
        seg_n[7] == 1'b1);

    // R6
    ones_lit_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && (anode_n[0] == 1'b0 || anode_n[NUM_DIGITS/2] == 1'b0))
            |-> seg_n[6:0] != 7'h7F);
endmodule

bind tone_setting_display tsd_chk #(
    .NUM_DIGITS (8),
    .SCAN_DIV   (SCAN_DIV)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .anode_n (anode_n),
    .seg_n   (seg_n)
);

// File: tb/tone_setting_display_tb.sv
module tone_setting_display_tb;
    localparam int DIV  = 4;
    localparam int NDIG = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] freq_code = '0;
    logic [2:0] vol_code  = '0;
    logic [7:0] anode_n;
    logic [7:0] seg_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tone_setting_display #(.SCAN_DIV(DIV)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .freq_code (freq_code),
        .vol_code  (vol_code),
        .anode_n   (anode_n),
        .seg_n     (seg_n)
    );

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    function automatic int pow10(input int p);
        int r = 1;
        for (int i = 0; i < p; i++) r = r * 10;
        return r;
    endfunction

    function automatic logic [7:0] exp_seg(input int value, input int pos);
        if (pos > 0 && value < pow10(pos)) return 8'hFF;
        return {1'b1, ~pat((value / pow10(pos)) % 10)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(anode_n == 8'hFF && seg_n == 8'hFF, "R1 reset outputs",
              {anode_n, seg_n}, 16'hFFFF);
        freq_code = 3'd0;
        vol_code  = 3'd0;
        rst = 1'b0;
        // R1: digit 0 first, for DIV cycles
        for (int i = 0; i < DIV; i++) begin
            @(negedge clk);
            check(anode_n == 8'hFE, "R1 first digit after reset",
                  {8'h00, anode_n}, 16'h00FE);
        end

        for (int f = 0; f < 8; f++) begin
            for (int v = 0; v < 8; v++) begin
                int fval;
                int vval;
                int prev_idx;
                int cnt[NDIG];
                freq_code = 3'(f);
                vol_code  = 3'(v);
                fval = f * 500;
                vval = (v * 100 + 3) / 7;
                prev_idx = -1;
                for (int k = 0; k < NDIG; k++) cnt[k] = 0;
                for (int s = 0; s < NDIG * DIV; s++) begin
                    int idx;
                    int ones;
                    logic [7:0] es;
                    string tag;
                    @(negedge clk);
                    idx = -1;
                    ones = 0;
                    for (int k = 0; k < NDIG; k++)
                        if (anode_n[k] == 1'b0) begin idx = k; ones++; end
                    // R2: single active-low anode
                    check(ones == 1, "R2 one anode low", {8'h00, anode_n}, 16'h0000);
                    if (ones != 1) continue;
                    cnt[idx]++;
                    // R3: order
                    if (prev_idx >= 0 && idx != prev_idx)
                        check(idx == (prev_idx + 1) % NDIG, "R3 scan order",
                              16'(idx), 16'((prev_idx + 1) % NDIG));
                    prev_idx = idx;
                    if (idx < 4) es = exp_seg(fval, idx);
                    else         es = exp_seg(vval, idx - 4);
                    if (s == 0)            tag = "R8 new code visible";
                    else if (es == 8'hFF)  tag = "R6 leading zero blank";
                    else if (idx < 4)      tag = "R4 frequency digit R7";
                    else                   tag = "R5 volume digit R7";
                    check(seg_n == es, tag, {8'(idx), seg_n}, {8'(idx), es});
                end
                // R3: dwell per digit
                for (int k = 0; k < NDIG; k++)
                    check(cnt[k] == DIV, "R3 dwell length", 16'(cnt[k]), 16'(DIV));
            end
        end
        finish_run();
    end
endmodule